// File: doc/BRIEF.md
# Interrupt Source State Controller

This block keeps the per-source bookkeeping for a bank of interrupt inputs and turns input activity into interrupt offers for a presentation stage. Each source is either level-sensitive or message-style, carries a target server, a priority and a saved priority, and tracks four status flags: asserted, sent, rejected and masked-pending. A source's global number is a fixed base plus its index. Offers leave on a valid/ready channel and carry the server, the global number and the priority.

The presentation side talks back through a message port. A reject hands an offer back to the source. An end-of-interrupt closes a level source's delivery. A resend request starts a scan over every source, one per cycle, that replays deliveries a level source still owes and offers rejected message work again. Configuration writes can release work that was held back while the priority was 0xFF (the masked priority). A type port sets each source's kind. This setting has no reset and so survives a block reset.

Top module: `src_ctl`

## Requirements
- R1: After reset every source reads priority 0xFF, saved priority 0xFF, server 0 and status 0, `offer_valid` is 0 and `scan_busy` is 0.
- R2: `typ_we` sets the kind of source `typ_idx` (1 = level, 0 = message) and clears its status. Reset does not change the kind.
- R3: A message source's trigger (`ev_level` = 1) sets masked-pending (status bit 3) when its priority is 0xFF. Otherwise it makes an offer with the source's server, priority and the number BASE + index.
- R4: A level source's event copies `ev_level` into asserted (status bit 0), then runs the send check: with priority not 0xFF, asserted set and sent (bit 1) clear, it sets sent and makes one offer.
- R5: A reject (`msg_kind` = 1) sets rejected (status bit 2) on a message source and clears sent on a level source.
- R6: An end-of-interrupt (`msg_kind` = 2) clears sent on a level source and leaves a message source unchanged.
- R7: A resend (`msg_kind` = 3) raises `scan_busy` and visits sources 0 to NUM_SRC-1, one per cycle. A level source runs the send check. A message source with rejected set clears it and is offered again if its priority is not 0xFF. A resend while busy is ignored.
- R8: A configuration write stores server, priority and saved priority. A message source with masked-pending and a new priority other than 0xFF clears masked-pending and is offered. A level source runs the send check.
- R9: Reject and end-of-interrupt numbers outside BASE to BASE+NUM_SRC-1 change no state.
- R10: While `offer_valid` is high and `offer_ready` is low, the offer fields hold, and the resend scan does not advance. Queued offers go out one per handshake.
- R11: The read port returns the server, priority, saved priority and status (bit 0 asserted, 1 sent, 2 rejected, 3 masked-pending) of source `rd_idx`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| typ_we | input | 1 | Source kind write strobe |
| typ_idx | input | IDX_W | Source index for the kind write |
| typ_level | input | 1 | 1 = level source, 0 = message source |
| ev_valid | input | 1 | Input event strobe |
| ev_idx | input | IDX_W | Source index of the event |
| ev_level | input | 1 | Level value, or trigger for a message source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Source index for the configuration write |
| cfg_server | input | SRV_W | New target server |
| cfg_prio | input | PRIO_W | New priority |
| cfg_saved | input | PRIO_W | New saved priority |
| msg_valid | input | 1 | Presentation message strobe |
| msg_kind | input | 2 | 1 reject, 2 end-of-interrupt, 3 resend |
| msg_num | input | NUM_W | Global interrupt number of the message |
| offer_valid | output | 1 | Offer present |
| offer_ready | input | 1 | Offer accepted |
| offer_server | output | SRV_W | Target server of the offer |
| offer_num | output | NUM_W | Global number of the offer |
| offer_prio | output | PRIO_W | Priority of the offer |
| scan_busy | output | 1 | Resend scan in progress |
| rd_idx | input | IDX_W | Source index to read |
| rd_server | output | SRV_W | Server of the read source |
| rd_prio | output | PRIO_W | Priority of the read source |
| rd_saved | output | PRIO_W | Saved priority of the read source |
| rd_stat | output | 4 | Status flags of the read source |

## Verification
The bench builds the block with six sources, a base of 32 and a 10-bit number field. Six is not a power of two, so the unused index codes 6 and 7 exist, and the six-cycle scan fits well inside each step's wait window. With a base of 32, the out-of-range numbers 27 (below the window) and 42 (above it) share their low three bits with real sources. This lets reject filtering be told apart from plain truncation of the number.

// File: rtl/src_ctl_pkg.sv
package src_ctl_pkg;
   // presentation-side message codes
   typedef enum logic [1:0] {
      MSG_NONE   = 2'd0,
      MSG_REJECT = 2'd1,
      MSG_EOI    = 2'd2,
      MSG_RESEND = 2'd3
   } msg_kind_e;

   // status flag positions
   localparam int ST_W        = 4;
   localparam int ST_ASSERTED = 0;
   localparam int ST_SENT     = 1;
   localparam int ST_REJECTED = 2;
   localparam int ST_MPEND    = 3;
endpackage

// File: rtl/src_slot.sv
module src_slot
   import src_ctl_pkg::*;
#(
   parameter int SRV_W  = 4,
   parameter int PRIO_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_level,
   input  logic              typ_hit,
   input  logic              ev_hit,
   input  logic              ev_val,
   input  logic              cfg_hit,
   input  logic [SRV_W-1:0]  cfg_server,
   input  logic [PRIO_W-1:0] cfg_prio,
   input  logic [PRIO_W-1:0] cfg_saved,
   input  logic              rej_hit,
   input  logic              eoi_hit,
   input  logic              scan_hit,
   input  logic              take,
   output logic [SRV_W-1:0]  server,
   output logic [PRIO_W-1:0] prio,
   output logic [PRIO_W-1:0] saved,
   output logic [ST_W-1:0]   stat,
   output logic              queued
);
   localparam logic [PRIO_W-1:0] MASKED = {PRIO_W{1'b1}};

   logic [SRV_W-1:0]  srv_q, srv_d;
   logic [PRIO_W-1:0] pr_q, pr_d, sv_q, sv_d;
   logic [ST_W-1:0]   st_q, st_d;
   logic              q_q, want;

   // events are applied in a fixed order: kind change, config, input, message, scan
   always_comb begin
      srv_d = srv_q;
      pr_d  = pr_q;
      sv_d  = sv_q;
      st_d  = st_q;
      want  = 1'b0;
      if (typ_hit) st_d = '0;
      if (cfg_hit) begin
         srv_d = cfg_server;
         pr_d  = cfg_prio;
         sv_d  = cfg_saved;
         if (is_level) begin
            if (pr_d != MASKED && st_d[ST_ASSERTED] && !st_d[ST_SENT]) begin
               st_d[ST_SENT] = 1'b1;
               want = 1'b1;
            end
         end else if (st_d[ST_MPEND] && pr_d != MASKED) begin
            st_d[ST_MPEND] = 1'b0;
            want = 1'b1;
         end
      end
      if (ev_hit) begin
         if (is_level) begin
            st_d[ST_ASSERTED] = ev_val;
            if (pr_d != MASKED && st_d[ST_ASSERTED] && !st_d[ST_SENT]) begin
               st_d[ST_SENT] = 1'b1;
               want = 1'b1;
            end
         end else if (ev_val) begin
            if (pr_d == MASKED) st_d[ST_MPEND] = 1'b1;
            else                want = 1'b1;
         end
      end
      if (rej_hit) begin
         if (is_level) st_d[ST_SENT] = 1'b0;
         else          st_d[ST_REJECTED] = 1'b1;
      end
      if (eoi_hit && is_level) st_d[ST_SENT] = 1'b0;
      if (scan_hit) begin
         if (is_level) begin
            if (pr_d != MASKED && st_d[ST_ASSERTED] && !st_d[ST_SENT]) begin
               st_d[ST_SENT] = 1'b1;
               want = 1'b1;
            end
         end else if (st_d[ST_REJECTED]) begin
            st_d[ST_REJECTED] = 1'b0;
            if (pr_d != MASKED) want = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         srv_q <= '0;
         pr_q  <= MASKED;
         sv_q  <= MASKED;
         st_q  <= '0;
         q_q   <= 1'b0;
      end else begin
         srv_q <= srv_d;
         pr_q  <= pr_d;
         sv_q  <= sv_d;
         st_q  <= st_d;
         q_q   <= (q_q & ~take) | want;
      end
   end

   assign server = srv_q;
   assign prio   = pr_q;
   assign saved  = sv_q;
   assign stat   = st_q;
   assign queued = q_q;
endmodule

// File: rtl/offer_pick.sv
module offer_pick #(
   parameter int NUM_SRC = 8,
   parameter int IDX_W   = 3,
   parameter int SRV_W   = 4,
   parameter int PRIO_W  = 8,
   parameter int NUM_W   = 12,
   parameter int BASE    = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_SRC-1:0]        queued,
   input  logic [NUM_SRC*SRV_W-1:0]  srv_flat,
   input  logic [NUM_SRC*PRIO_W-1:0] pr_flat,
   input  logic                      ready,
   output logic [NUM_SRC-1:0]        take,
   output logic                      valid,
   output logic [SRV_W-1:0]          server,
   output logic [NUM_W-1:0]          num,
   output logic [PRIO_W-1:0]         prio
);
   localparam logic [NUM_W-1:0] BASE_V = NUM_W'(BASE);

   logic [IDX_W-1:0] sel;
   logic             found, load, v_q;

   // lowest queued index wins
   always_comb begin
      sel   = '0;
      found = 1'b0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (queued[i]) begin
            sel   = IDX_W'(i);
            found = 1'b1;
         end
      end
   end

   assign load = found && (!v_q || ready);

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_take
      assign take[g] = load && (sel == IDX_W'(g));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q    <= 1'b0;
         server <= '0;
         num    <= '0;
         prio   <= '0;
      end else if (load) begin
         v_q    <= 1'b1;
         server <= srv_flat[int'(sel)*SRV_W +: SRV_W];
         prio   <= pr_flat[int'(sel)*PRIO_W +: PRIO_W];
         num    <= BASE_V + NUM_W'(sel);
      end else if (ready) begin
         v_q    <= 1'b0;
      end
   end

   assign valid = v_q;
endmodule

// File: rtl/resend_scan.sv
module resend_scan #(
   parameter int NUM_SRC = 8,
   parameter int IDX_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               stall,
   output logic               busy,
   output logic [NUM_SRC-1:0] hit
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

   logic [IDX_W-1:0] idx_q;
   logic             busy_q;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_hit
      assign hit[g] = busy_q && !stall && (idx_q == IDX_W'(g));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
         end
      end else if (!stall) begin
         if (idx_q == LAST) busy_q <= 1'b0;
         else               idx_q  <= idx_q + 1'b1;
      end
   end

   assign busy = busy_q;
endmodule

// File: rtl/src_ctl.sv
module src_ctl
   import src_ctl_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int SRV_W   = 4,
   parameter int PRIO_W  = 8,
   parameter int NUM_W   = 12,
   parameter int BASE    = 16,
   parameter int IDX_W   = $clog2(NUM_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              typ_we,
   input  logic [IDX_W-1:0]  typ_idx,
   input  logic              typ_level,
   input  logic              ev_valid,
   input  logic [IDX_W-1:0]  ev_idx,
   input  logic              ev_level,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic [SRV_W-1:0]  cfg_server,
   input  logic [PRIO_W-1:0] cfg_prio,
   input  logic [PRIO_W-1:0] cfg_saved,
   input  logic              msg_valid,
   input  logic [1:0]        msg_kind,
   input  logic [NUM_W-1:0]  msg_num,
   output logic              offer_valid,
   input  logic              offer_ready,
   output logic [SRV_W-1:0]  offer_server,
   output logic [NUM_W-1:0]  offer_num,
   output logic [PRIO_W-1:0] offer_prio,
   output logic              scan_busy,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [SRV_W-1:0]  rd_server,
   output logic [PRIO_W-1:0] rd_prio,
   output logic [PRIO_W-1:0] rd_saved,
   output logic [ST_W-1:0]   rd_stat
);
   localparam logic [NUM_W-1:0] BASE_V = NUM_W'(BASE);
   localparam logic [NUM_W-1:0] LIM_V  = NUM_W'(BASE + NUM_SRC);

   // elaboration-time parameter checks
   if (NUM_SRC < 2) begin : g_bad_count
      $error("src_ctl: NUM_SRC must be at least 2");
   end
   if (IDX_W < $clog2(NUM_SRC)) begin : g_bad_idx
      $error("src_ctl: IDX_W too narrow for NUM_SRC");
   end
   if (BASE < 0 || BASE + NUM_SRC >= (1 << NUM_W)) begin : g_bad_base
      $error("src_ctl: number window does not fit NUM_W");
   end
   if (PRIO_W < 1 || SRV_W < 1) begin : g_bad_width
      $error("src_ctl: field widths must be positive");
   end

   logic [NUM_SRC-1:0]        lvl_q;
   logic [NUM_SRC-1:0]        typ_hit, ev_hit, cfg_hit, rej_hit, eoi_hit, scan_hit;
   logic [NUM_SRC-1:0]        queued, take;
   logic [NUM_SRC*SRV_W-1:0]  srv_flat;
   logic [NUM_SRC*PRIO_W-1:0] pr_flat, sv_flat;
   logic [NUM_SRC*ST_W-1:0]   stat_flat;
   logic [NUM_W-1:0]          rel;
   logic                      in_rng, is_rej, is_eoi, resend_req, stall;

   assign rel        = msg_num - BASE_V;
   assign in_rng     = (msg_num >= BASE_V) && (msg_num < LIM_V);
   assign is_rej     = msg_valid && (msg_kind == MSG_REJECT) && in_rng;
   assign is_eoi     = msg_valid && (msg_kind == MSG_EOI) && in_rng;
   assign resend_req = msg_valid && (msg_kind == MSG_RESEND);
   assign stall      = offer_valid && !offer_ready;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      assign typ_hit[g] = typ_we   && (typ_idx == IDX_W'(g));
      assign ev_hit[g]  = ev_valid && (ev_idx  == IDX_W'(g));
      assign cfg_hit[g] = cfg_we   && (cfg_idx == IDX_W'(g));
      assign rej_hit[g] = is_rej   && (rel == NUM_W'(g));
      assign eoi_hit[g] = is_eoi   && (rel == NUM_W'(g));

      // source kind has no reset: it survives a block reset
      always_ff @(posedge clk) begin
         if (typ_hit[g]) lvl_q[g] <= typ_level;
      end

      src_slot #(.SRV_W(SRV_W), .PRIO_W(PRIO_W)) u_slot (
         .clk        (clk),
         .rst_n      (rst_n),
         .is_level   (lvl_q[g]),
         .typ_hit    (typ_hit[g]),
         .ev_hit     (ev_hit[g]),
         .ev_val     (ev_level),
         .cfg_hit    (cfg_hit[g]),
         .cfg_server (cfg_server),
         .cfg_prio   (cfg_prio),
         .cfg_saved  (cfg_saved),
         .rej_hit    (rej_hit[g]),
         .eoi_hit    (eoi_hit[g]),
         .scan_hit   (scan_hit[g]),
         .take       (take[g]),
         .server     (srv_flat[g*SRV_W +: SRV_W]),
         .prio       (pr_flat[g*PRIO_W +: PRIO_W]),
         .saved      (sv_flat[g*PRIO_W +: PRIO_W]),
         .stat       (stat_flat[g*ST_W +: ST_W]),
         .queued     (queued[g])
      );
   end

   resend_scan #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_scan (
      .clk   (clk),
      .rst_n (rst_n),
      .start (resend_req),
      .stall (stall),
      .busy  (scan_busy),
      .hit   (scan_hit)
   );

   offer_pick #(
      .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .SRV_W(SRV_W),
      .PRIO_W(PRIO_W), .NUM_W(NUM_W), .BASE(BASE)
   ) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .queued   (queued),
      .srv_flat (srv_flat),
      .pr_flat  (pr_flat),
      .ready    (offer_ready),
      .take     (take),
      .valid    (offer_valid),
      .server   (offer_server),
      .num      (offer_num),
      .prio     (offer_prio)
   );

   // state read port
   always_comb begin
      rd_server = '0;
      rd_prio   = '0;
      rd_saved  = '0;
      rd_stat   = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (rd_idx == IDX_W'(i)) begin
            rd_server = srv_flat[i*SRV_W +: SRV_W];
            rd_prio   = pr_flat[i*PRIO_W +: PRIO_W];
            rd_saved  = sv_flat[i*PRIO_W +: PRIO_W];
            rd_stat   = stat_flat[i*ST_W +: ST_W];
         end
      end
   end
endmodule

// File: rtl/src_ctl_chk.sv
module src_ctl_chk
   import src_ctl_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int SRV_W   = 4,
   parameter int PRIO_W  = 8,
   parameter int NUM_W   = 12,
   parameter int BASE    = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    offer_valid,
   input logic                    offer_ready,
   input logic [SRV_W-1:0]        offer_server,
   input logic [NUM_W-1:0]        offer_num,
   input logic [PRIO_W-1:0]       offer_prio,
   input logic                    scan_busy,
   input logic                    msg_valid,
   input logic [1:0]              msg_kind,
   input logic [NUM_SRC-1:0]      lvl,
   input logic [NUM_SRC*ST_W-1:0] stat_flat
);
   assert_offer_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      offer_valid && !offer_ready |=> offer_valid && $stable(offer_num)
                                      && $stable(offer_prio) && $stable(offer_server));

   assert_num_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      offer_valid |-> (offer_num >= NUM_W'(BASE)) && (offer_num < NUM_W'(BASE + NUM_SRC)));

   assert_scan_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      scan_busy && offer_valid && !offer_ready |=> scan_busy);

   assert_scan_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scan_busy) |-> $past(msg_valid && msg_kind == MSG_RESEND));

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
      assert_level_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
         lvl[g] |-> !stat_flat[g*ST_W + ST_REJECTED] && !stat_flat[g*ST_W + ST_MPEND]);
   end
endmodule

bind src_ctl src_ctl_chk #(
   .NUM_SRC(NUM_SRC), .SRV_W(SRV_W), .PRIO_W(PRIO_W), .NUM_W(NUM_W), .BASE(BASE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .offer_valid  (offer_valid),
   .offer_ready  (offer_ready),
   .offer_server (offer_server),
   .offer_num    (offer_num),
   .offer_prio   (offer_prio),
   .scan_busy    (scan_busy),
   .msg_valid    (msg_valid),
   .msg_kind     (msg_kind),
   .lvl          (lvl_q),
   .stat_flat    (stat_flat)
);

// File: tb/tb_src_ctl.sv
module tb_src_ctl;
   localparam int N  = 6;
   localparam int B  = 32;
   localparam int NW = 10;
   localparam int SW = 4;
   localparam int PW = 8;
   localparam int IW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic typ_we = 0, typ_level = 0, ev_valid = 0, ev_level = 0, cfg_we = 0, msg_valid = 0;
   logic [IW-1:0] typ_idx = 0, ev_idx = 0, cfg_idx = 0, rd_idx = 0;
   logic [SW-1:0] cfg_server = 0;
   logic [PW-1:0] cfg_prio = 0, cfg_saved = 0;
   logic [1:0]    msg_kind = 0;
   logic [NW-1:0] msg_num = 0;
   logic          offer_ready = 1'b1;
   logic          offer_valid, scan_busy;
   logic [SW-1:0] offer_server, rd_server;
   logic [NW-1:0] offer_num;
   logic [PW-1:0] offer_prio, rd_prio, rd_saved;
   logic [3:0]    rd_stat;

   always #5 clk = ~clk;

   src_ctl #(.NUM_SRC(N), .SRV_W(SW), .PRIO_W(PW), .NUM_W(NW), .BASE(B), .IDX_W(IW)) dut (
      .clk(clk), .rst_n(rst_n),
      .typ_we(typ_we), .typ_idx(typ_idx), .typ_level(typ_level),
      .ev_valid(ev_valid), .ev_idx(ev_idx), .ev_level(ev_level),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server),
      .cfg_prio(cfg_prio), .cfg_saved(cfg_saved),
      .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_num(msg_num),
      .offer_valid(offer_valid), .offer_ready(offer_ready),
      .offer_server(offer_server), .offer_num(offer_num), .offer_prio(offer_prio),
      .scan_busy(scan_busy),
      .rd_idx(rd_idx), .rd_server(rd_server), .rd_prio(rd_prio),
      .rd_saved(rd_saved), .rd_stat(rd_stat)
   );

   int n_chk = 0, n_fail = 0, n_off = 0;
   logic [NW-1:0] last_num;
   logic [PW-1:0] last_prio;
   logic [SW-1:0] last_srv;
   logic done = 1'b0;

   // offers taken at the next edge are seen here
   always @(negedge clk) begin
      if (rst_n && offer_valid && offer_ready) begin
         n_off++;
         last_num  = offer_num;
         last_prio = offer_prio;
         last_srv  = offer_server;
      end
   end

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // op: 0 event, 1 config, 2 reject, 3 eoi, 4 resend
   typedef struct packed {
      logic [2:0] op;
      logic [7:0] arg;   // source index or global number
      logic [7:0] val;   // level / priority
      logic [3:0] srv;   // config server, or expected server
      logic [1:0] en;    // expected new offers
      logic [7:0] enum_; // expected number
      logic [7:0] ep;    // expected priority
      logic [3:0] req;
   } row_t;

   localparam int NROW = 23;
   localparam row_t TBL [NROW] = '{
      '{3'd1, 8'd2,  8'h05, 4'd3, 2'd0, 8'd0,  8'h00, 4'd8}, // R8 msg config, nothing pending
      '{3'd0, 8'd2,  8'h01, 4'd3, 2'd1, 8'd34, 8'h05, 4'd3}, // R3 trigger offers
      '{3'd0, 8'd3,  8'h01, 4'd0, 2'd0, 8'd0,  8'h00, 4'd3}, // R3 masked -> pending
      '{3'd1, 8'd3,  8'h07, 4'd1, 2'd1, 8'd35, 8'h07, 4'd8}, // R8 unmask releases
      '{3'd1, 8'd0,  8'h04, 4'd2, 2'd0, 8'd0,  8'h00, 4'd8}, // R8 level not asserted
      '{3'd0, 8'd0,  8'h01, 4'd2, 2'd1, 8'd32, 8'h04, 4'd4}, // R4 assert sends
      '{3'd0, 8'd0,  8'h01, 4'd0, 2'd0, 8'd0,  8'h00, 4'd4}, // R4 already sent
      '{3'd3, 8'd32, 8'h00, 4'd0, 2'd0, 8'd0,  8'h00, 4'd6}, // R6 eoi level
      '{3'd4, 8'd0,  8'h00, 4'd2, 2'd1, 8'd32, 8'h04, 4'd7}, // R7 level resent
      '{3'd2, 8'd34, 8'h00, 4'd0, 2'd0, 8'd0,  8'h00, 4'd5}, // R5 reject msg
      '{3'd4, 8'd0,  8'h00, 4'd3, 2'd1, 8'd34, 8'h05, 4'd7}, // R7 rejected msg again
      '{3'd4, 8'd0,  8'h00, 4'd0, 2'd0, 8'd0,  8'h00, 4'd7}, // R7 rejected cleared
      '{3'd2, 8'd32, 8'h00, 4'd0, 2'd0, 8'd0,  8'h00, 4'd5}, // R5 reject level
      '{3'd4, 8'd0,  8'h00, 4'd2, 2'd1, 8'd32, 8'h04, 4'd5}, // R5 sent was cleared
      '{3'd0, 8'd0,  8'h00, 4'd0, 2'd0, 8'd0,  8'h00, 4'd4}, // R4 deassert
      '{3'd3, 8'd32, 8'h00, 4'd0, 2'd0, 8'd0,  8'h00, 4'd6}, // R6
      '{3'd4, 8'd0,  8'h00, 4'd0, 2'd0, 8'd0,  8'h00, 4'd4}, // R4 not asserted
      '{3'd3, 8'd34, 8'h00, 4'd0, 2'd0, 8'd0,  8'h00, 4'd6}, // R6 eoi msg
      '{3'd4, 8'd0,  8'h00, 4'd0, 2'd0, 8'd0,  8'h00, 4'd6}, // R6 no effect
      '{3'd2, 8'd42, 8'h00, 4'd0, 2'd0, 8'd0,  8'h00, 4'd9}, // R9 above window
      '{3'd4, 8'd0,  8'h00, 4'd0, 2'd0, 8'd0,  8'h00, 4'd9}, // R9
      '{3'd2, 8'd27, 8'h00, 4'd0, 2'd0, 8'd0,  8'h00, 4'd9}, // R9 below window
      '{3'd4, 8'd0,  8'h00, 4'd0, 2'd0, 8'd0,  8'h00, 4'd9}  // R9
   };

   task automatic clr;
      typ_we = 0; ev_valid = 0; cfg_we = 0; msg_valid = 0;
   endtask

   task automatic apply(input row_t r);
      @(negedge clk);
      case (r.op)
         3'd0: begin ev_valid = 1; ev_idx = IW'(r.arg); ev_level = r.val[0]; end
         3'd1: begin cfg_we = 1; cfg_idx = IW'(r.arg); cfg_prio = r.val;
                     cfg_server = r.srv; cfg_saved = r.val ^ 8'h10; end
         3'd2: begin msg_valid = 1; msg_kind = 2'd1; msg_num = NW'(r.arg); end
         3'd3: begin msg_valid = 1; msg_kind = 2'd2; msg_num = NW'(r.arg); end
         default: begin msg_valid = 1; msg_kind = 2'd3; msg_num = '0; end
      endcase
      @(negedge clk);
      clr();
   endtask

   task automatic set_type(input int idx, input logic lv);
      @(negedge clk);
      typ_we = 1; typ_idx = IW'(idx); typ_level = lv;
      @(negedge clk);
      clr();
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int base_off;
      do_reset();
      // R1 reset state
      for (int i = 0; i < N; i++) begin
         rd_idx = IW'(i);
         #1;
         chk(rd_prio == 8'hFF && rd_saved == 8'hFF, "R1 prio/saved", {rd_prio, rd_saved}, 16'hFFFF);
         chk(rd_server == 0 && rd_stat == 0, "R1 server/status", {rd_server, rd_stat}, 0);
      end
      chk(!offer_valid && !scan_busy, "R1 outputs idle", {offer_valid, scan_busy}, 0);

      // R2 kinds: sources 0,1 level, others message
      for (int i = 0; i < N; i++) set_type(i, i < 2);

      // table walk
      for (int k = 0; k < NROW; k++) begin
         base_off = n_off;
         apply(TBL[k]);
         repeat (12) @(negedge clk);
         chk(n_off - base_off == int'(TBL[k].en), $sformatf("R%0d row %0d offers", TBL[k].req, k),
             n_off - base_off, TBL[k].en);
         if (TBL[k].en != 0) begin
            chk(last_num == NW'(TBL[k].enum_) && last_prio == TBL[k].ep && last_srv == TBL[k].srv,
                $sformatf("R%0d row %0d offer fields", TBL[k].req, k),
                {last_srv, last_prio, last_num}, {TBL[k].srv, TBL[k].ep, NW'(TBL[k].enum_)});
         end
      end

      // R11 / R8 read port after configuration
      rd_idx = 3'd2;
      #1;
      chk(rd_prio == 8'h05 && rd_saved == 8'h15 && rd_server == 4'd3, "R11 readback",
          {rd_server, rd_prio, rd_saved}, {4'd3, 8'h05, 8'h15});

      // R10 back-pressure: offer holds, scan stalls
      offer_ready = 1'b0;
      apply('{3'd1, 8'd4, 8'h09, 4'd5, 2'd0, 8'd0, 8'h00, 4'd8});
      apply('{3'd0, 8'd4, 8'h01, 4'd0, 2'd0, 8'd0, 8'h00, 4'd3});
      apply('{3'd0, 8'd2, 8'h01, 4'd0, 2'd0, 8'd0, 8'h00, 4'd3});
      apply('{3'd4, 8'd0, 8'h00, 4'd0, 2'd0, 8'd0, 8'h00, 4'd7});
      repeat (4) @(negedge clk);
      chk(offer_valid && offer_num == NW'(36) && offer_prio == 8'h09, "R10 offer held",
          offer_num, 36);
      chk(scan_busy, "R10 scan stalled", scan_busy, 1);
      base_off = n_off;
      offer_ready = 1'b1;
      @(negedge clk);
      chk(n_off - base_off == 1 && last_num == NW'(36), "R10 first offer taken", last_num, 36);
      @(negedge clk);
      chk(n_off - base_off == 2 && last_num == NW'(34), "R10 queued offer next", last_num, 34);
      repeat (10) @(negedge clk);
      chk(!scan_busy && n_off - base_off == 2, "R7 scan finished", n_off - base_off, 2);

      // R2 kind survives reset
      set_type(5, 1'b1);
      do_reset();
      rd_idx = 3'd5;
      #1;
      chk(rd_prio == 8'hFF && rd_stat == 0, "R1 after second reset", {rd_prio, rd_stat}, 16'hFF0);
      base_off = n_off;
      apply('{3'd1, 8'd5, 8'h03, 4'd1, 2'd0, 8'd0, 8'h00, 4'd2});
      apply('{3'd0, 8'd5, 8'h01, 4'd0, 2'd0, 8'd0, 8'h00, 4'd2});
      repeat (4) @(negedge clk);
      rd_idx = 3'd5;
      #1;
      chk(rd_stat == 4'b0011, "R2 src5 still level", rd_stat, 4'b0011);
      chk(n_off - base_off == 1 && last_num == NW'(37), "R2 src5 offer", last_num, 37);
      apply('{3'd0, 8'd0, 8'h01, 4'd0, 2'd0, 8'd0, 8'h00, 4'd2});
      apply('{3'd0, 8'd2, 8'h01, 4'd0, 2'd0, 8'd0, 8'h00, 4'd2});
      rd_idx = 3'd0;
      #1;
      chk(rd_stat == 4'b0001, "R2 src0 still level", rd_stat, 4'b0001);
      rd_idx = 3'd2;
      #1;
      chk(rd_stat == 4'b1000, "R2 src2 still message", rd_stat, 4'b1000);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule